// File: doc/BRIEF.md
# Write-Protected Watchdog and Interval Timer

This block counts ticks of one of two clock-enable inputs in a free-running counter. When the number of ticks since the last clear reaches a selectable power of two, the counter expires. In watchdog mode an expiry drives a system reset pulse. In interval mode an expiry instead sets an interrupt flag, and the counter keeps running so that the flag is set again once per period.

Software reaches the block through one 16-bit control register. A write changes the register only when its upper byte carries the key 5Ah. A write with any other upper byte is treated as a tampering attempt and raises the system reset at once. A read returns the fixed byte 69h in the upper half, so read-modify-write code has to substitute the key before writing back. The same register also holds two configuration bits that the block only passes on to the reset/NMI pin logic elsewhere in the chip.

Top module: `wdg_timer`

## Requirements
- R1: After power-on reset, rdData reads 6900h (watchdog mode, not held, clock A, longest interval), and sysRstOut, irqFlag and irqReq are 0.
- R2: A write whose upper byte is 5Ah loads the lower byte. A read always returns 69h in bits 15:8 and the stored lower byte in bits 7:0, with bit 3 (counter clear) always reading 0.
- R3: A write whose upper byte is not 5Ah raises sysRstOut at the next clock edge. The pulse lasts exactly RST_LEN cycles, after which the control register reads 6900h.
- R4: With bit 4 at 0 (watchdog mode), the expiry raises sysRstOut at the tick that completes 2^n ticks after a clear. The control register then returns to 6900h when the pulse ends.
- R5: With bit 4 at 1 (interval mode), an expiry sets irqFlag and never raises sysRstOut. The flag is set again every 2^n ticks while the counter runs.
- R6: Bits 1:0 select n: 00 selects TAP_EXP0, 01 TAP_EXP1, 10 TAP_EXP2 and 11 TAP_EXP3 (defaults 15, 13, 9, 6).
- R7: Bit 2 selects the tick source: 0 counts cycles with clkEnA high, 1 counts cycles with clkEnB high; the other enable is ignored.
- R8: Bit 7 (hold) stops the counter, so no expiry and no reset occur while it is set.
- R9: Writing bit 3 as 1 zeroes the counter at that write's clock edge, so the next expiry comes a full 2^n ticks later.
- R10: A high flagClr clears irqFlag at the next edge. irqReq is high exactly when irqFlag and irqEn are both high.
- R11: nmiEdge follows stored bit 6 and nmiSel follows stored bit 5.
- R12: Writes that arrive while sysRstOut is high are ignored, keyed or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-on reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Write data: key in 15:8, control bits in 7:0 |
| rdData | output | 16 | Read data: 69h and the control bits |
| clkEnA | input | 1 | Tick enable of the fast clock source |
| clkEnB | input | 1 | Tick enable of the auxiliary clock source |
| irqEn | input | 1 | Interrupt enable for the interval flag |
| flagClr | input | 1 | Clears the interval flag |
| sysRstOut | output | 1 | System reset pulse |
| irqFlag | output | 1 | Interval expiry flag |
| irqReq | output | 1 | Interrupt request (flag gated by enable) |
| nmiSel | output | 1 | Reset pin configured for NMI function |
| nmiEdge | output | 1 | NMI edge polarity select |

## Verification
The bench builds the block with tap exponents 10, 8, 5 and 3 and a reset pulse of 4 cycles. With these values all four interval encodings, a watchdog expiry and two consecutive interval periods each finish in at most 1024 ticks. The defaults would need up to 32768 ticks per period. Because the exponents differ, a wrong tap decode shows up as a wrong expiry cycle. The auxiliary enable toggles every cycle, so a swapped source changes the period by a factor of two.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [7:0] WR_KEY = 8'h5A;
  localparam logic [7:0] RD_ID  = 8'h69;

  localparam int HOLD_BIT    = 7;
  localparam int NMIEDGE_BIT = 6;
  localparam int NMISEL_BIT  = 5;
  localparam int MODE_BIT    = 4;
  localparam int CLR_BIT     = 3;
  localparam int SRC_BIT     = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic       cntClr;
    logic       hold;
    logic       srcSel;
    logic [1:0] tapSel;
  } ctlStrobe_t;
endpackage

// File: rtl/wdg_dpath.sv
module wdg_dpath
  import wdg_pkg::*;
#(
  parameter int TAP_EXP0 = 15,
  parameter int TAP_EXP1 = 13,
  parameter int TAP_EXP2 = 9,
  parameter int TAP_EXP3 = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkEnA,
  input  logic       clkEnB,
  input  ctlStrobe_t st,
  output logic       expire
);
  localparam int EXPS [4] = '{TAP_EXP0, TAP_EXP1, TAP_EXP2, TAP_EXP3};
  localparam int M01 = (TAP_EXP0 > TAP_EXP1) ? TAP_EXP0 : TAP_EXP1;
  localparam int M23 = (TAP_EXP2 > TAP_EXP3) ? TAP_EXP2 : TAP_EXP3;
  localparam int CNT_W = (M01 > M23) ? M01 : M23;

  logic [CNT_W-1:0] cnt;
  logic [3:0]       tapHit;
  logic             tick;

  assign tick = !st.hold && (st.srcSel ? clkEnB : clkEnA);

  // one all-ones detector per selectable interval
  for (genvar g = 0; g < 4; g++) begin : gTap
    assign tapHit[g] = &cnt[EXPS[g]-1:0];
  end

  assign expire = tick && tapHit[st.tapSel] && !st.cntClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (st.cntClr) cnt <= '0;
    else if (tick)      cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int RST_LEN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic        expire,
  input  logic        flagClr,
  output ctlStrobe_t  st,
  output logic [15:0] rdData,
  output logic        sysRstOut,
  output logic        irqFlag,
  output logic        nmiSel,
  output logic        nmiEdge
);
  localparam int RST_W = $clog2(RST_LEN + 1);

  logic [7:0]       ctlReg;
  logic [RST_W-1:0] rstCnt;
  logic             rstActive;
  logic             keyOk;
  logic             wrOk;
  logic             keyBad;
  logic             intervalMode;

  assign rstActive    = (rstCnt != '0);
  assign keyOk        = (wrData[15:8] == WR_KEY);
  assign wrOk         = wrEn && keyOk && !rstActive;
  assign keyBad       = wrEn && !keyOk && !rstActive;
  assign intervalMode = ctlReg[MODE_BIT];

  // control register; the clear bit is never stored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ctlReg <= '0;
    else if (rstActive) ctlReg <= '0;
    else if (wrOk)      ctlReg <= wrData[7:0] & ~(8'(1) << CLR_BIT);
  end

  // system reset pulse generator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             rstCnt <= '0;
    else if (rstActive)                    rstCnt <= rstCnt - RST_W'(1);
    else if (keyBad || (expire && !intervalMode)) rstCnt <= RST_W'(RST_LEN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         irqFlag <= 1'b0;
    else if (rstActive)                irqFlag <= 1'b0;
    else if (expire && intervalMode)   irqFlag <= 1'b1;
    else if (flagClr)                  irqFlag <= 1'b0;
  end

  always_comb begin
    st.cntClr = rstActive || (wrOk && wrData[CLR_BIT]);
    st.hold   = ctlReg[HOLD_BIT];
    st.srcSel = ctlReg[SRC_BIT];
    st.tapSel = ctlReg[1:0];
  end

  assign rdData    = {RD_ID, ctlReg};
  assign sysRstOut = rstActive;
  assign nmiSel    = ctlReg[NMISEL_BIT];
  assign nmiEdge   = ctlReg[NMIEDGE_BIT];
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int TAP_EXP0 = 15,
  parameter int TAP_EXP1 = 13,
  parameter int TAP_EXP2 = 9,
  parameter int TAP_EXP3 = 6,
  parameter int RST_LEN  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic        clkEnA,
  input  logic        clkEnB,
  input  logic        irqEn,
  input  logic        flagClr,
  output logic        sysRstOut,
  output logic        irqFlag,
  output logic        irqReq,
  output logic        nmiSel,
  output logic        nmiEdge
);
  ctlStrobe_t st;
  logic       expire;

  wdg_ctrl #(.RST_LEN(RST_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .expire(expire), .flagClr(flagClr), .st(st), .rdData(rdData),
    .sysRstOut(sysRstOut), .irqFlag(irqFlag), .nmiSel(nmiSel), .nmiEdge(nmiEdge)
  );

  wdg_dpath #(
    .TAP_EXP0(TAP_EXP0), .TAP_EXP1(TAP_EXP1),
    .TAP_EXP2(TAP_EXP2), .TAP_EXP3(TAP_EXP3)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .clkEnA(clkEnA), .clkEnB(clkEnB),
    .st(st), .expire(expire)
  );

  assign irqReq = irqFlag && irqEn;
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrKey,
  input logic [7:0] rdId,
  input logic       rdHold,
  input logic       rdMode,
  input logic       rdClr,
  input logic       sysRstOut,
  input logic       irqFlag
);
  assert_key_violation_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrKey != 8'h5A && !sysRstOut) |=> sysRstOut);

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstOut) |=> sysRstOut);

  assert_read_id_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdId == 8'h69) && !rdClr);

  assert_no_reset_in_interval_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstOut) |-> ($past(wrEn) || !$past(rdMode)));

  assert_flag_only_interval_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(rdMode));

  assert_hold_no_expiry_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdHold && !wrEn && !sysRstOut) |=> !sysRstOut);

  assert_flag_cleared_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sysRstOut && $past(sysRstOut)) |-> !irqFlag);
endmodule

bind wdg_timer wdg_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrKey(wrData[15:8]),
  .rdId(rdData[15:8]), .rdHold(rdData[7]), .rdMode(rdData[4]), .rdClr(rdData[3]),
  .sysRstOut(sysRstOut), .irqFlag(irqFlag)
);

// File: tb/sim_wdg_timer.sv
`timescale 1ns/1ps
module sim_wdg_timer;
  logic        clk = 0;
  logic        rstN = 0;
  logic        wrEn = 0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        clkEnA = 1;
  logic        clkEnB = 0;
  logic        irqEn = 0;
  logic        flagClr = 0;
  logic        sysRstOut, irqFlag, irqReq, nmiSel, nmiEdge;
  int          nRun = 0;
  int          nFail = 0;

  localparam int RLEN = 4;

  wdg_timer #(.TAP_EXP0(10), .TAP_EXP1(8), .TAP_EXP2(5), .TAP_EXP3(3), .RST_LEN(RLEN)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .clkEnA(clkEnA), .clkEnB(clkEnB), .irqEn(irqEn), .flagClr(flagClr),
    .sysRstOut(sysRstOut), .irqFlag(irqFlag), .irqReq(irqReq),
    .nmiSel(nmiSel), .nmiEdge(nmiEdge)
  );

  always #10 clk = ~clk;

  // auxiliary enable toggles every cycle
  initial forever begin
    @(negedge clk);
    clkEnB = ~clkEnB;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // write; flagClr rides along with every write
  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wrEn = 1; wrData = d; flagClr = 1;
    @(negedge clk);
    wrEn = 0; flagClr = 0;
  endtask

  task automatic period(input logic [7:0] lowb, input int n, input bit useRst, input string tag);
    wr({8'h5A, lowb});
    repeat (n - 1) @(negedge clk);
    chk({tag, " before expiry"}, useRst ? sysRstOut : irqFlag, 0);
    @(negedge clk);
    chk({tag, " at expiry"}, useRst ? sysRstOut : irqFlag, 1);
  endtask

  task automatic t_reset;
    chk("R1 rdData", rdData, 32'h6900);
    chk("R1 sysRstOut", sysRstOut, 0);
    chk("R1 irqFlag", irqFlag, 0);
    chk("R1 irqReq", irqReq, 0);
  endtask

  task automatic t_regs;
    wr(16'h5A5F);
    chk("R2 read keeps 69h, bit3 reads 0", rdData, 32'h6957);
    chk("R11 nmiEdge", nmiEdge, 1);
    chk("R11 nmiSel", nmiSel, 0);
    wr(16'h5A20);
    chk("R2 second read", rdData, 32'h6920);
    chk("R11 nmiSel set", nmiSel, 1);
    chk("R11 nmiEdge clear", nmiEdge, 0);
  endtask

  task automatic t_taps;
    period(8'h18, 1024, 0, "R6 tap 00");
    period(8'h19, 256, 0, "R6 tap 01");
    period(8'h1A, 32, 0, "R6 tap 10");
    period(8'h1B, 8, 0, "R5 tap 11");
    chk("R5 no reset in interval mode", sysRstOut, 0);
  endtask

  task automatic t_repeat_irq;
    period(8'h1B, 8, 0, "R5 first period");
    irqEn = 1; #1;
    chk("R10 irqReq enabled", irqReq, 1);
    irqEn = 0; #1;
    chk("R10 irqReq masked", irqReq, 0);
    flagClr = 1;
    @(negedge clk);
    flagClr = 0;
    chk("R10 flag cleared", irqFlag, 0);
    repeat (6) @(negedge clk);
    chk("R5 second period early", irqFlag, 0);
    @(negedge clk);
    chk("R5 second period", irqFlag, 1);
  endtask

  task automatic t_clear;
    wr(16'h5A1B);
    repeat (5) @(negedge clk);
    wr(16'h5A1B);
    repeat (7) @(negedge clk);
    chk("R9 cleared counter no early expiry", irqFlag, 0);
    @(negedge clk);
    chk("R9 full period after clear", irqFlag, 1);
  endtask

  task automatic t_source;
    wr(16'h5A1F);
    repeat (14) @(negedge clk);
    chk("R7 source B ignores A", irqFlag, 0);
    repeat (2) @(negedge clk);
    chk("R7 source B expiry", irqFlag, 1);
  endtask

  task automatic t_watchdog;
    period(8'h0A, 32, 1, "R4 watchdog");
    repeat (RLEN - 1) @(negedge clk);
    chk("R4 pulse still high", sysRstOut, 1);
    @(negedge clk);
    chk("R4 pulse ended", sysRstOut, 0);
    chk("R4 register restored", rdData, 32'h6900);
  endtask

  task automatic t_hold;
    bit seen = 0;
    wr(16'h5A80);
    repeat (2500) begin
      @(negedge clk);
      if (sysRstOut) seen = 1;
    end
    chk("R8 no reset while held", seen, 0);
    chk("R8 hold readback", rdData, 32'h6980);
  endtask

  task automatic t_violation;
    wr(16'hA580);
    chk("R3 reset raised", sysRstOut, 1);
    repeat (RLEN - 1) @(negedge clk);
    chk("R3 reset still high", sysRstOut, 1);
    @(negedge clk);
    chk("R3 reset length", sysRstOut, 0);
    chk("R3 register defaults", rdData, 32'h6900);
    wr(16'h6900);
    chk("R3 read id as key is a violation", sysRstOut, 1);
    wr(16'h5A80);
    repeat (4) @(negedge clk);
    chk("R12 write during reset ignored", rdData, 32'h6900);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_taps();
    t_repeat_irq();
    t_clear();
    t_source();
    t_watchdog();
    t_hold();
    t_violation();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule